// File: doc/BRIEF.md
# SPI Register Front End with Word FIFOs and Interrupts

This block sits between a simple register bus and the shift engine of an SPI master. Software writes words into an 8-entry transmit queue through a data address, and reads received words from an 8-entry receive queue through the same address. The engine takes words from the transmit queue over a valid/ready handshake and delivers received words with a single-cycle valid strobe.

Besides the queues, the block holds the enable bit and four configuration words that it passes through to the engine: clock divider, transmit word setup, receive word setup and frame setup. It also holds a status word, an interrupt enable mask, and interrupt flags that software clears by writing ones. Queue thresholds steer a receive-ready condition and two DMA request lines. Flush controls empty either queue in one cycle.

Register offsets (byte addresses): 0x00 enable, 0x04 clock divider, 0x08 transmit word setup, 0x0C receive word setup, 0x10 frame setup, 0x14 status, 0x18 interrupt enable, 0x1C interrupt flags (read) / flag clear (write), 0x20 queue control, 0x24 data. A read returns its value on `bus_rdata` in the cycle after `bus_rd` is sampled.

Top module: `spi_regfront`

## Requirements
- R1: After reset, ctl_en, irq, dreq_tx, dreq_rx and eng_tx_valid are 0, both queues are empty, and the status, queue control and flag registers read 0.
- R2: A write to 0x04, 0x08, 0x0C or 0x10 stores the full 32-bit word, which reads back unchanged and drives cfg_clk, cfg_txword, cfg_rxword or cfg_frame respectively.
- R3: A write to 0x24 appends the word to the transmit queue, and the engine receives the words in write order. A write to 0x24 while 8 words are queued is dropped.
- R4: A read of 0x24 returns the oldest received word and removes it from the queue. A read of 0x24 with an empty queue returns 0 and changes nothing.
- R5: A received word is taken only while enabled. A word arriving while the receive queue holds 8 words is dropped and sets the overrun flag (flag bit 0).
- R6: With a nonzero receive threshold (queue control bits 3:0), the receive-ready status (flag register bit 9) is 1 exactly while the receive level is at or above the threshold. While that holds, the receive-complete flag (bit 3) is set.
- R7: The transmit-complete flag (bit 4) is set when the engine takes the last queued word and no new word is written in that cycle.
- R8: Writing 1 to bit 4, 3 or 0 at 0x1C clears that flag. A set condition present in the same cycle wins over the clear.
- R9: irq is 1 exactly when a flag is set whose enable bit at 0x18 (bit 4 transmit complete, bit 3 receive complete, bit 0 overrun) is 1.
- R10: dreq_tx is 1 when enable bit 2 is set, the block is enabled, and the transmit level is at or below the transmit threshold (queue control bits 11:8). dreq_rx is 1 when enable bit 1 is set and receive-ready holds.
- R11: A write to 0x20 stores both thresholds. Bit 12 empties the transmit queue and bit 4 empties the receive queue, each in one cycle, and both read back as 0.
- R12: The status register at 0x14 reads bit 0 as receive queue not empty, and bit 7 as busy, which is eng_busy OR transmit queue not empty.
- R13: Bit 0 at 0x00 drives ctl_en. While it is 0, eng_tx_valid stays 0, so no queued word is handed out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 6 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after the read strobe |
| ctl_en | output | 1 | Controller enable to the engine |
| cfg_clk | output | 32 | Clock divider setting |
| cfg_txword | output | 32 | Transmit word setup |
| cfg_rxword | output | 32 | Receive word setup |
| cfg_frame | output | 32 | Frame setup |
| eng_tx_data | output | 32 | Word at the head of the transmit queue |
| eng_tx_valid | output | 1 | Transmit word available |
| eng_tx_ready | input | 1 | Engine takes the transmit word |
| eng_rx_data | input | 32 | Word from the engine |
| eng_rx_valid | input | 1 | Received word strobe |
| eng_busy | input | 1 | Engine is shifting |
| irq | output | 1 | Interrupt request |
| dreq_tx | output | 1 | Transmit DMA request |
| dreq_rx | output | 1 | Receive DMA request |

## Verification
The hardest situation to reach is the overrun drop, because it needs nine received words to land while software stays away from the data address. The bench drives nine engine strobes back to back with the receive threshold at 0 so that nothing else reacts. It then drains the queue through the data address and requires the eighth word to be the last one and the ninth read to return 0. The set-wins-over-clear rule is reached the same way: the bench clears receive-complete while the level still meets the threshold and expects the flag to read back as 1.

// File: rtl/spi_regfront_pkg.sv
package spi_regfront_pkg;

    localparam int DEPTH_DEF = 8;
    localparam int DATA_W    = 32;
    localparam int ADDR_W    = 6;
    localparam int TH_W      = 4;
    localparam int NUM_CFG   = 4;

    typedef enum logic [ADDR_W-1:0] {
        A_CTL  = 6'h00,
        A_CLK  = 6'h04,
        A_TXW  = 6'h08,
        A_RXW  = 6'h0C,
        A_FRM  = 6'h10,
        A_STAT = 6'h14,
        A_IE   = 6'h18,
        A_ISC  = 6'h1C,
        A_FCTL = 6'h20,
        A_DATA = 6'h24
    } reg_addr_e;

    // flag / enable bit positions
    localparam int B_TC     = 4;
    localparam int B_RC     = 3;
    localparam int B_DRQ_TX = 2;
    localparam int B_DRQ_RX = 1;
    localparam int B_OVR    = 0;
    localparam int B_RDY    = 9;
    localparam int B_BUSY   = 7;
    localparam int B_TXFL   = 12;
    localparam int B_RXFL   = 4;

    typedef struct packed {
        logic tc;
        logic rc;
        logic ovr;
    } irq_flags_t;

    function automatic irq_flags_t pick_flags(input logic [DATA_W-1:0] w);
        irq_flags_t f;
        f.tc  = w[B_TC];
        f.rc  = w[B_RC];
        f.ovr = w[B_OVR];
        return f;
    endfunction

endpackage

// File: rtl/spi_rf_fifo.sv
module spi_rf_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 8,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic          push,
    input  logic [W-1:0]  pdata,
    input  logic          pop,
    output logic [W-1:0]  head,
    output logic [LW-1:0] count,
    output logic          full,
    output logic          empty
);
    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wptr, rptr;
    logic          push_ok, pop_ok;

    function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    assign full    = (count == LW'(DEPTH));
    assign empty   = (count == '0);
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign head    = mem[rptr];

    always_ff @(posedge clk) begin
        if (push_ok && !flush) mem[wptr] <= pdata;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (push_ok) wptr <= nxt(wptr);
            if (pop_ok)  rptr <= nxt(rptr);
            count <= count + LW'(push_ok) - LW'(pop_ok);
        end
    end
endmodule

// File: rtl/spi_rf_irq.sv
module spi_rf_irq
    import spi_regfront_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  irq_flags_t set_f,
    input  irq_flags_t clr_f,
    input  irq_flags_t mask_f,
    output irq_flags_t flags,
    output logic       irq
);
    always_ff @(posedge clk) begin
        if (rst) flags <= '0;
        else     flags <= (flags & ~clr_f) | set_f;
    end

    assign irq = |(flags & mask_f);
endmodule

// File: rtl/spi_regfront.sv
module spi_regfront
    import spi_regfront_pkg::*;
#(
    parameter int DEPTH = DEPTH_DEF,
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              ctl_en,
    output logic [DATA_W-1:0] cfg_clk,
    output logic [DATA_W-1:0] cfg_txword,
    output logic [DATA_W-1:0] cfg_rxword,
    output logic [DATA_W-1:0] cfg_frame,
    output logic [DATA_W-1:0] eng_tx_data,
    output logic              eng_tx_valid,
    input  logic              eng_tx_ready,
    input  logic [DATA_W-1:0] eng_rx_data,
    input  logic              eng_rx_valid,
    input  logic              eng_busy,
    output logic              irq,
    output logic              dreq_tx,
    output logic              dreq_rx
);
    logic              en_q;
    logic [4:0]        ie_q;
    logic [TH_W-1:0]   txth_q, rxth_q;
    logic [DATA_W-1:0] cfg_q [NUM_CFG];

    logic [LW-1:0]     tx_cnt, rx_cnt;
    logic              tx_full, tx_empty, rx_full, rx_empty;
    logic [DATA_W-1:0] rx_head;
    logic              wr_data, rd_data, wr_fctl, wr_isc;
    logic              tx_flush, rx_flush, tx_pop, rx_push, rx_ready;
    irq_flags_t        flags, set_f, clr_f, mask_f;
    logic [DATA_W-1:0] rd_mux;

    assign wr_data  = bus_wr && (bus_addr == A_DATA);
    assign rd_data  = bus_rd && (bus_addr == A_DATA);
    assign wr_fctl  = bus_wr && (bus_addr == A_FCTL);
    assign wr_isc   = bus_wr && (bus_addr == A_ISC);
    assign tx_flush = wr_fctl && bus_wdata[B_TXFL];
    assign rx_flush = wr_fctl && bus_wdata[B_RXFL];

    assign eng_tx_valid = en_q && !tx_empty;
    assign tx_pop       = eng_tx_valid && eng_tx_ready;
    assign rx_push      = en_q && eng_rx_valid;
    assign rx_ready     = (rxth_q != '0) && (32'(rx_cnt) >= 32'(rxth_q));

    // control registers
    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= 1'b0;
            ie_q   <= '0;
            txth_q <= '0;
            rxth_q <= '0;
        end else if (bus_wr) begin
            case (bus_addr)
                A_CTL:  en_q <= bus_wdata[0];
                A_IE:   ie_q <= bus_wdata[4:0];
                A_FCTL: begin
                    txth_q <= bus_wdata[8 +: TH_W];
                    rxth_q <= bus_wdata[0 +: TH_W];
                end
                default: ;
            endcase
        end
    end

    // pass-through configuration bank
    for (genvar g = 0; g < NUM_CFG; g++) begin : g_cfg
        localparam logic [ADDR_W-1:0] CFG_ADDR = ADDR_W'(int'(A_CLK) + 4 * g);
        always_ff @(posedge clk) begin
            if (rst)                                  cfg_q[g] <= '0;
            else if (bus_wr && bus_addr == CFG_ADDR)  cfg_q[g] <= bus_wdata;
        end
    end
    assign cfg_clk    = cfg_q[0];
    assign cfg_txword = cfg_q[1];
    assign cfg_rxword = cfg_q[2];
    assign cfg_frame  = cfg_q[3];

    spi_rf_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_txq (
        .clk(clk), .rst(rst), .flush(tx_flush),
        .push(wr_data), .pdata(bus_wdata), .pop(tx_pop),
        .head(eng_tx_data), .count(tx_cnt), .full(tx_full), .empty(tx_empty)
    );

    spi_rf_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_rxq (
        .clk(clk), .rst(rst), .flush(rx_flush),
        .push(rx_push), .pdata(eng_rx_data), .pop(rd_data),
        .head(rx_head), .count(rx_cnt), .full(rx_full), .empty(rx_empty)
    );

    // flag sources
    assign set_f.tc  = tx_pop && (tx_cnt == LW'(1)) && !wr_data;
    assign set_f.rc  = rx_ready;
    assign set_f.ovr = rx_push && rx_full;
    assign clr_f     = wr_isc ? pick_flags(bus_wdata) : '0;
    assign mask_f    = pick_flags({27'd0, ie_q});

    spi_rf_irq u_irq (
        .clk(clk), .rst(rst), .set_f(set_f), .clr_f(clr_f),
        .mask_f(mask_f), .flags(flags), .irq(irq)
    );

    assign dreq_tx = ie_q[B_DRQ_TX] && en_q && (32'(tx_cnt) <= 32'(txth_q));
    assign dreq_rx = ie_q[B_DRQ_RX] && rx_ready;
    assign ctl_en  = en_q;

    // read path
    always_comb begin
        rd_mux = '0;
        case (bus_addr)
            A_CTL:  rd_mux[0] = en_q;
            A_STAT: begin
                rd_mux[B_BUSY] = eng_busy || !tx_empty;
                rd_mux[0]      = !rx_empty;
            end
            A_IE:   rd_mux[4:0] = ie_q;
            A_ISC:  begin
                rd_mux[B_RDY] = rx_ready;
                rd_mux[B_TC]  = flags.tc;
                rd_mux[B_RC]  = flags.rc;
                rd_mux[B_OVR] = flags.ovr;
            end
            A_FCTL: begin
                rd_mux[8 +: TH_W] = txth_q;
                rd_mux[0 +: TH_W] = rxth_q;
            end
            A_DATA: rd_mux = rx_empty ? '0 : rx_head;
            default: begin
                for (int i = 0; i < NUM_CFG; i++)
                    if (bus_addr == ADDR_W'(int'(A_CLK) + 4 * i)) rd_mux = cfg_q[i];
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)         bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_mux;
    end
endmodule

// File: rtl/spi_regfront_chk.sv
module spi_regfront_chk
    import spi_regfront_pkg::*;
#(
    parameter int DEPTH = DEPTH_DEF,
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input logic              clk,
    input logic              rst,
    input logic              ctl_en,
    input logic              eng_tx_valid,
    input logic              eng_rx_valid,
    input logic              dreq_tx,
    input logic              irq,
    input logic [4:0]        ie_q,
    input logic [LW-1:0]     tx_cnt,
    input logic [LW-1:0]     rx_cnt,
    input logic              ovr_flag,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              txfl_bit
);
    a_r13_valid_needs_en: assert property (@(posedge clk) disable iff (rst)
        eng_tx_valid |-> ctl_en);

    a_r10_dreq_tx_needs_en: assert property (@(posedge clk) disable iff (rst)
        dreq_tx |-> ctl_en);

    a_r9_irq_masked: assert property (@(posedge clk) disable iff (rst)
        (ie_q == '0) |-> !irq);

    a_r3_tx_bound: assert property (@(posedge clk) disable iff (rst)
        32'(tx_cnt) <= DEPTH);

    a_r5_rx_bound: assert property (@(posedge clk) disable iff (rst)
        32'(rx_cnt) <= DEPTH);

    a_r5_overrun_sets: assert property (@(posedge clk) disable iff (rst)
        (ctl_en && eng_rx_valid && rx_cnt == LW'(DEPTH)) |=> ovr_flag);

    a_r11_tx_flush: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == A_FCTL && txfl_bit) |=> (tx_cnt == '0));
endmodule

bind spi_regfront spi_regfront_chk #(.DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst(rst), .ctl_en(ctl_en), .eng_tx_valid(eng_tx_valid),
    .eng_rx_valid(eng_rx_valid), .dreq_tx(dreq_tx), .irq(irq), .ie_q(ie_q),
    .tx_cnt(tx_cnt), .rx_cnt(rx_cnt), .ovr_flag(flags.ovr), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .txfl_bit(bus_wdata[12])
);

// File: tb/spi_regfront_bench.sv
module spi_regfront_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        bus_wr, bus_rd;
    logic [5:0]  bus_addr;
    logic [31:0] bus_wdata, bus_rdata;
    logic        ctl_en;
    logic [31:0] cfg_clk, cfg_txword, cfg_rxword, cfg_frame;
    logic [31:0] eng_tx_data, eng_rx_data;
    logic        eng_tx_valid, eng_tx_ready, eng_rx_valid, eng_busy;
    logic        irq, dreq_tx, dreq_rx;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    spi_regfront u_spi_regfront (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ctl_en(ctl_en), .cfg_clk(cfg_clk), .cfg_txword(cfg_txword),
        .cfg_rxword(cfg_rxword), .cfg_frame(cfg_frame),
        .eng_tx_data(eng_tx_data), .eng_tx_valid(eng_tx_valid),
        .eng_tx_ready(eng_tx_ready), .eng_rx_data(eng_rx_data),
        .eng_rx_valid(eng_rx_valid), .eng_busy(eng_busy), .irq(irq),
        .dreq_tx(dreq_tx), .dreq_rx(dreq_rx)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(posedge clk);
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic rx_word(input logic [31:0] d);
        @(negedge clk);
        eng_rx_valid = 1'b1; eng_rx_data = d;
        @(posedge clk);
        @(negedge clk);
        eng_rx_valid = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        chk("R1 ctl_en", {31'd0, ctl_en}, 0);
        chk("R1 irq", {31'd0, irq}, 0);
        chk("R1 dreq", {30'd0, dreq_tx, dreq_rx}, 0);
        chk("R1 tx_valid", {31'd0, eng_tx_valid}, 0);
        rd(6'h14, v); chk("R1 status", v, 0);
        rd(6'h20, v); chk("R1 fctl", v, 0);
        rd(6'h1C, v); chk("R1 flags", v, 0);
    endtask

    task automatic t_config();
        logic [31:0] v;
        wr(6'h04, 32'hDEAD_0012);
        wr(6'h08, 32'h0000_1F20);
        wr(6'h0C, 32'h8000_0007);
        wr(6'h10, 32'h0000_C000);
        chk("R2 cfg_clk", cfg_clk, 32'hDEAD_0012);
        chk("R2 cfg_txword", cfg_txword, 32'h0000_1F20);
        chk("R2 cfg_rxword", cfg_rxword, 32'h8000_0007);
        chk("R2 cfg_frame", cfg_frame, 32'h0000_C000);
        rd(6'h0C, v); chk("R2 readback rxword", v, 32'h8000_0007);
    endtask

    task automatic t_tx();
        logic [31:0] v;
        wr(6'h18, 32'h10);
        for (int i = 0; i < 9; i++) wr(6'h24, 32'hA0 + i);
        idle(1);
        chk("R13 no valid while disabled", {31'd0, eng_tx_valid}, 0);
        rd(6'h14, v); chk("R12 busy from queued tx", v, 32'h80);
        wr(6'h00, 32'h1);
        chk("R13 ctl_en", {31'd0, ctl_en}, 1);
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            chk("R3 tx valid", {31'd0, eng_tx_valid}, 1);
            chk("R3 tx order", eng_tx_data, 32'hA0 + i);
            eng_tx_ready = 1'b1;
            @(posedge clk);
        end
        @(negedge clk);
        eng_tx_ready = 1'b0;
        chk("R3 ninth word dropped", {31'd0, eng_tx_valid}, 0);
        idle(1);
        rd(6'h1C, v); chk("R7 tc flag", v, 32'h10);
        chk("R9 irq on tc", {31'd0, irq}, 1);
        wr(6'h1C, 32'h10);
        idle(1);
        rd(6'h1C, v); chk("R8 tc cleared", v, 0);
        chk("R9 irq released", {31'd0, irq}, 0);
    endtask

    task automatic t_rx();
        logic [31:0] v;
        wr(6'h20, 32'h4);
        wr(6'h18, 32'h0A);
        for (int i = 0; i < 3; i++) rx_word(32'h5000 + i);
        idle(2);
        rd(6'h1C, v); chk("R6 below threshold", v, 0);
        chk("R10 dreq_rx low", {31'd0, dreq_rx}, 0);
        rx_word(32'h5003);
        idle(2);
        rd(6'h1C, v); chk("R6 ready and rc", v, 32'h208);
        chk("R10 dreq_rx high", {31'd0, dreq_rx}, 1);
        chk("R9 irq on rc", {31'd0, irq}, 1);
        wr(6'h1C, 32'h08);
        idle(1);
        rd(6'h1C, v); chk("R8 set wins over clear", v & 32'h8, 32'h8);
        for (int i = 0; i < 4; i++) begin
            rd(6'h24, v); chk("R4 rx order", v, 32'h5000 + i);
        end
        rd(6'h14, v); chk("R12 rx empty", v, 0);
        rd(6'h24, v); chk("R4 empty read", v, 0);
        wr(6'h1C, 32'h08);
        idle(1);
        rd(6'h1C, v); chk("R8 rc cleared", v, 0);
        chk("R10 dreq_rx released", {31'd0, dreq_rx}, 0);
    endtask

    task automatic t_overrun();
        logic [31:0] v;
        wr(6'h20, 32'h0);
        wr(6'h18, 32'h01);
        for (int i = 0; i < 9; i++) rx_word(32'h100 + i);
        idle(1);
        rd(6'h1C, v); chk("R5 overrun flag", v, 32'h1);
        chk("R9 irq on overrun", {31'd0, irq}, 1);
        for (int i = 0; i < 8; i++) rd(6'h24, v);
        chk("R5 last kept word", v, 32'h107);
        rd(6'h24, v); chk("R5 ninth dropped", v, 0);
        wr(6'h1C, 32'h1);
        idle(1);
        chk("R8 ovr cleared irq", {31'd0, irq}, 0);
        rx_word(32'h77); rx_word(32'h78);
        rd(6'h14, v); chk("R12 rx not empty", v, 32'h1);
        wr(6'h20, 32'h10);
        rd(6'h14, v); chk("R11 rx flush", v, 0);
        wr(6'h00, 32'h0);
        rx_word(32'h99);
        rd(6'h14, v); chk("R5 ignored while disabled", v, 0);
    endtask

    task automatic t_dreq_tx();
        logic [31:0] v;
        wr(6'h00, 32'h1);
        wr(6'h20, 32'h0200);
        wr(6'h18, 32'h04);
        idle(1);
        chk("R10 dreq_tx empty", {31'd0, dreq_tx}, 1);
        for (int i = 0; i < 3; i++) wr(6'h24, 32'hC0 + i);
        idle(1);
        chk("R10 dreq_tx above th", {31'd0, dreq_tx}, 0);
        wr(6'h20, 32'h1200);
        idle(1);
        chk("R11 tx flush", {31'd0, eng_tx_valid}, 0);
        chk("R10 dreq_tx after flush", {31'd0, dreq_tx}, 1);
        rd(6'h20, v); chk("R11 fctl readback", v, 32'h0200);
        wr(6'h00, 32'h0);
        idle(1);
        chk("R13 dreq off when disabled", {31'd0, dreq_tx}, 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        rst = 1'b1;
        bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0; bus_wdata = '0;
        eng_tx_ready = 1'b0; eng_rx_valid = 1'b0; eng_rx_data = '0; eng_busy = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_config();
        t_tx();
        t_rx();
        t_overrun();
        t_dreq_tx();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule